// File: doc/BRIEF.md
# Trigger-Gated Period Timer

This block runs a 16-bit up-counter with a programmable period and one pulse-width output, and it starts and stops that counter from a single asynchronous trigger pin. One edge of the pin starts counting. The opposite level of the pin requests a stop and holds the counter at zero. A polarity select chooses which edge starts and which level stops. Configuration comes from register-style inputs that are held steady: a run enable, the polarity, the stop behaviour, a one-time flag, the period and the compare value.

A stop request takes effect in one of two ways. It can clear the counter and drop the output at once, or it can let the running period finish and stop at the period match. In one-time mode the first stop also locks the block. Start edges are then refused until the one-time flag is cleared. Clearing the run enable always stops the counter and clears it, whatever the pin is doing.

Top module: `trig_gate_timer`

## Requirements
- R1: The trigger pin passes through two synchronizer flops before edge detection. If the pin becomes active between clock edges k-1 and k, `running_o` rises at edge k+2 and `count_o` reads 0 in that cycle.
- R2: With `trig_pol_i` = 1, a falling edge starts the counter and a high pin level is the stop level. Timing is the same as in R1.
- R3: While running, `count_o` steps by one each cycle from 0 up to `period_i`, then wraps to 0 and keeps counting.
- R4: While running, `pwm_o` is 1 exactly when `count_o` is greater than `compare_i` and not greater than `period_i` (for compare < period). It is 0 otherwise, and its initial level is 0.
- R5: While stopped, `count_o` is 0 and `pwm_o` is 0. A stop level on the pin keeps the counter stopped. A change of polarity that creates no edge on the synchronized pin does not start it.
- R6: With `stop_at_end_i` = 0, a stop level that becomes visible while running clears the counter, drops `pwm_o` and clears `running_o` three edges after the pin changes.
- R7: With `stop_at_end_i` = 1, a stop level lets counting continue to the period match. The counter then returns to 0 and stops in the cycle after `count_o` equals `period_i`.
- R8: While `run_en_i` is 0, pin edges and levels are ignored. Clearing `run_en_i` stops and clears the counter at the next edge.
- R9: With `one_shot_i` = 1, a start edge that follows a stop is refused. Starts are accepted again once `one_shot_i` has been 0 for one cycle.
- R10: After reset, `count_o` is 0, `pwm_o` is 0, `running_o` is 0 and no start is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Run enable; 0 stops the counter and ignores the trigger |
| trig_pol_i | input | 1 | 0: rising edge starts, low level stops; 1: falling edge starts, high level stops |
| stop_at_end_i | input | 1 | 0: stop at once; 1: stop at the end of the period |
| one_shot_i | input | 1 | 1: refuse restarts after a stop |
| trig_pin_i | input | 1 | Asynchronous trigger pin |
| period_i | input | 16 | Last count value of a period |
| compare_i | input | 16 | Count value after which the output goes high |
| count_o | output | 16 | Counter value |
| pwm_o | output | 1 | Pulse-width output |
| running_o | output | 1 | 1 while the counter is counting |

## Verification
The bench measures the start latency through the synchronizer to the exact cycle. A design with one flop too many or too few shows `running_o` one cycle off. It stops the counter partway through a period while the output is high, in both stop modes. A design that confused the modes would either keep counting after an immediate stop or cut off the rest of the period. It checks that a polarity change alone causes no start, that the pin has no effect while the run enable is low, and that one-time mode refuses a restart and accepts one again after the flag is cleared. A lock that never clears, or never sets, shows up as a wrong `running_o`.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e state;
        logic       lock;
    } tgt_ctrl_t;

endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic pol_i,
    output logic start_edge_o,
    output logic stop_lvl_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;
    logic               act_now, act_prev;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    // Normalise to "active" so that one detector serves both polarities
    assign act_now      = chain_q[SYNC_STAGES-1] ^ pol_i;
    assign act_prev     = chain_q[SYNC_STAGES] ^ pol_i;
    assign start_edge_o = act_now & ~act_prev;
    assign stop_lvl_o   = ~act_now;

endmodule

// File: rtl/tgt_counter.sv
module tgt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pwm_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             pwm;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!step_i) begin
            cnt_d.count = '0;
            cnt_d.pwm   = 1'b0;
        end else if (cnt_q.count == period_i) begin
            cnt_d.count = '0;
            cnt_d.pwm   = 1'b0;
        end else begin
            cnt_d.count = cnt_q.count + 1'b1;
            if (cnt_q.count == compare_i) cnt_d.pwm = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.count;
    assign pwm_o   = cnt_q.pwm;
    assign wrap_o  = (cnt_q.count == period_i);

endmodule

// File: rtl/trig_gate_timer.sv
module trig_gate_timer
    import tgt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_en_i,
    input  logic             trig_pol_i,
    input  logic             stop_at_end_i,
    input  logic             one_shot_i,
    input  logic             trig_pin_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pwm_o,
    output logic             running_o
);
    tgt_ctrl_t ctrl_d, ctrl_q;
    logic      start_edge, stop_lvl, wrap, step;
    logic      busy_q;

    tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pin_i        (trig_pin_i),
        .pol_i        (trig_pol_i),
        .start_edge_o (start_edge),
        .stop_lvl_o   (stop_lvl)
    );

    assign busy_q = (ctrl_q.state != ST_IDLE);

    always_comb begin
        ctrl_d = ctrl_q;
        if (!one_shot_i) ctrl_d.lock = 1'b0;
        if (!run_en_i) begin
            ctrl_d.state = ST_IDLE;
        end else begin
            unique case (ctrl_q.state)
                ST_IDLE: begin
                    if (start_edge && !ctrl_q.lock) ctrl_d.state = ST_RUN;
                end
                ST_RUN: begin
                    if (stop_lvl) begin
                        if (stop_at_end_i) begin
                            ctrl_d.state = ST_DRAIN;
                        end else begin
                            ctrl_d.state = ST_IDLE;
                            ctrl_d.lock  = one_shot_i;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (wrap) begin
                        ctrl_d.state = ST_IDLE;
                        ctrl_d.lock  = one_shot_i;
                    end
                end
                default: ctrl_d.state = ST_IDLE;
            endcase
        end
        // Count only while running now and still running next cycle
        step = busy_q && (ctrl_d.state != ST_IDLE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.state <= ST_IDLE;
            ctrl_q.lock  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    tgt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .period_i  (period_i),
        .compare_i (compare_i),
        .count_o   (count_o),
        .pwm_o     (pwm_o),
        .wrap_o    (wrap)
    );

    assign running_o = busy_q;

endmodule

// File: rtl/tgt_checker.sv
module tgt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_en_i,
    input logic [CNT_W-1:0] period_i,
    input logic [CNT_W-1:0] count_o,
    input logic             pwm_o,
    input logic             running_o
);
    AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running_o) |-> (count_o == '0)); // R1

    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && run_en_i && count_o != period_i) |=>
        (!running_o || count_o == CNT_W'($past(count_o) + 1'b1))); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && count_o == period_i) |=> (count_o == '0)); // R3

    AST_PWM_LOW_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && count_o == period_i) |=> !pwm_o); // R4

    AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_o |-> (count_o == '0 && !pwm_o)); // R5

    AST_DISABLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_en_i |=> (!running_o && count_o == '0)); // R8

endmodule

bind trig_gate_timer tgt_checker #(.CNT_W(CNT_W)) u_tgt_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_en_i  (run_en_i),
    .period_i  (period_i),
    .count_o   (count_o),
    .pwm_o     (pwm_o),
    .running_o (running_o)
);

// File: tb/trig_gate_timer_test.sv
`timescale 1ns/1ps
module trig_gate_timer_test;
    localparam int W   = 16;
    localparam int PER = 9;
    localparam int CMP = 4;
    localparam int WATCHDOG_NS = 40000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0, pol = 1'b0, at_end = 1'b0, once = 1'b0, pin = 1'b0;
    logic [W-1:0]  period = W'(PER), compare = W'(CMP);
    logic [W-1:0]  count;
    logic          pwm, running;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int    t;
        int    cnt;
        bit    pw;
        bit    run;
        string rid;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_gate_timer #(.CNT_W(W)) uut (
        .clk_i (clk), .rst_ni (rst_n), .run_en_i (run_en), .trig_pol_i (pol),
        .stop_at_end_i (at_end), .one_shot_i (once), .trig_pin_i (pin),
        .period_i (period), .compare_i (compare),
        .count_o (count), .pwm_o (pwm), .running_o (running)
    );

    // Driver side: push expected outputs for an absolute cycle
    task automatic exp_abs(int t, int c, bit p, bit r, string rid);
        exp_t e;
        e.t = t; e.cnt = c; e.pw = p; e.run = r; e.rid = rid;
        sb.push_back(e);
    endtask

    // Expected running values for a counter that started (count 0) at cycle s
    task automatic exp_phase(int s, int t, string rid);
        int c;
        c = (t - s) % (PER + 1);
        exp_abs(t, c, (c > CMP), 1'b1, rid);
    endtask

    task automatic to_cyc(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every expected item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].t == cyc) begin
                n_vec++;
                if (int'(count) != sb[i].cnt || pwm != sb[i].pw || running != sb[i].run) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d: count=%0d pwm=%0b run=%0b expected count=%0d pwm=%0b run=%0b",
                             sb[i].rid, cyc, count, pwm, running, sb[i].cnt, sb[i].pw, sb[i].run);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        #(WATCHDOG_NS);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: cycle=%0d expected run to end before %0d ns", cyc, WATCHDOG_NS);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int n, s, m;
        wait_n(4);
        rst_n = 1'b1;
        exp_abs(cyc + 1, 0, 1'b0, 1'b0, "R10");
        exp_abs(cyc + 3, 0, 1'b0, 1'b0, "R10");
        run_en = 1'b1;
        wait_n(4);

        // R1 / R3 / R4: rising edge start with polarity 0
        n = cyc; pin = 1'b1; s = n + 3;
        exp_abs(n + 2, 0, 1'b0, 1'b0, "R1");
        exp_phase(s, s, "R1");
        exp_phase(s, s + 2, "R3");
        exp_phase(s, s + 4, "R4");
        exp_phase(s, s + 5, "R4");
        exp_phase(s, s + 9, "R4");
        exp_phase(s, s + 10, "R3");
        exp_phase(s, s + 11, "R3");
        exp_phase(s, s + 15, "R4");
        to_cyc(s + 16);

        // R6: immediate stop while the output is high
        m = cyc; pin = 1'b0;
        exp_phase(s, m + 2, "R6");
        exp_abs(m + 3, 0, 1'b0, 1'b0, "R6");
        exp_abs(m + 8, 0, 1'b0, 1'b0, "R5");
        to_cyc(m + 10);

        // R5 / R2: polarity flip without an edge, then falling-edge start
        pol = 1'b1;
        exp_abs(cyc + 5, 0, 1'b0, 1'b0, "R5");
        wait_n(6);
        pin = 1'b1;
        wait_n(5);
        n = cyc; pin = 1'b0; s = n + 3;
        exp_abs(n + 2, 0, 1'b0, 1'b0, "R2");
        exp_phase(s, s, "R2");
        exp_phase(s, s + 6, "R2");
        to_cyc(s + 7);
        m = cyc; pin = 1'b1;
        exp_abs(m + 3, 0, 1'b0, 1'b0, "R2");
        to_cyc(m + 6);
        pol = 1'b0;
        exp_abs(cyc + 4, 0, 1'b0, 1'b0, "R5");
        wait_n(5);
        pin = 1'b0;
        wait_n(5);

        // R7: stop at end of period
        at_end = 1'b1;
        n = cyc; pin = 1'b1; s = n + 3;
        to_cyc(s + 3);
        pin = 1'b0;
        exp_phase(s, s + 6, "R7");
        exp_phase(s, s + 9, "R7");
        exp_abs(s + 10, 0, 1'b0, 1'b0, "R7");
        exp_abs(s + 13, 0, 1'b0, 1'b0, "R7");
        to_cyc(s + 15);
        at_end = 1'b0;

        // R8: clearing run enable stops at once; pin ignored while disabled
        n = cyc; pin = 1'b1; s = n + 3;
        to_cyc(s + 5);
        run_en = 1'b0;
        exp_phase(s, s + 5, "R8");
        exp_abs(s + 6, 0, 1'b0, 1'b0, "R8");
        wait_n(3);
        pin = 1'b0;
        wait_n(4);
        n = cyc; pin = 1'b1;
        exp_abs(n + 3, 0, 1'b0, 1'b0, "R8");
        exp_abs(n + 6, 0, 1'b0, 1'b0, "R8");
        wait_n(7);
        pin = 1'b0;
        wait_n(4);
        run_en = 1'b1;
        wait_n(3);

        // R9: one-time mode refuses a restart until cleared
        once = 1'b1;
        n = cyc; pin = 1'b1; s = n + 3;
        exp_phase(s, s + 1, "R9");
        to_cyc(s + 3);
        pin = 1'b0;
        exp_abs(s + 6, 0, 1'b0, 1'b0, "R9");
        to_cyc(s + 9);
        n = cyc; pin = 1'b1;
        exp_abs(n + 3, 0, 1'b0, 1'b0, "R9");
        exp_abs(n + 6, 0, 1'b0, 1'b0, "R9");
        wait_n(7);
        pin = 1'b0;
        wait_n(4);
        once = 1'b0;
        wait_n(2);
        n = cyc; pin = 1'b1; s = n + 3;
        exp_phase(s, s, "R9");
        exp_phase(s, s + 2, "R9");
        to_cyc(s + 20);

        if (sb.size() != 0) begin
            n_bad += sb.size();
            foreach (sb[i])
                $display("FAIL %s cycle %0d: count=never sampled expected count=%0d", sb[i].rid, sb[i].t, sb[i].cnt);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule